// File: doc/BRIEF.md
# Glitch-Free Clock Gate with Selectable Polarity

This block lets a clock through, or holds it back, under the control of a single enable, and it never emits a shortened pulse. The enable is captured in a level-sensitive latch while the clock sits at its idle level. The latched value is then combined with the clock, so that a decision made before an active edge stays fixed for the whole pulse that follows.

A compile-time parameter picks the polarity. In rising mode the output rests Low while gated and passes High pulses. In falling mode it rests High and passes Low pulses. An asynchronous active-low reset clears the latched enable, so the output sits at its resting level from the start.

Top module: `cg_gate`

## Requirements
- R1: While `rst_ni` is 0, the output holds its resting level: 0 in rising mode and 1 in falling mode. This holds whatever `clk_i` and `en_i` do.
- R2: In rising mode, when `en_i` is 1 ahead of a rising edge of `clk_i`, the output is 1 for the whole High phase that follows that edge.
- R3: In rising mode, when `en_i` is 0 ahead of a rising edge, the output stays 0 through that clock period, and it is always 0 while `clk_i` is 0.
- R4: In rising mode, changes of `en_i` while `clk_i` is 1 do not affect the current phase. A pulse that has started completes in full.
- R5: In falling mode, when `en_i` is 0 ahead of a falling edge, the output stays 1 through that clock period, and it is always 1 while `clk_i` is 1.
- R6: In falling mode, when `en_i` is 1 ahead of a falling edge, the output is 0 for the whole Low phase. Changes of `en_i` while `clk_i` is 0 do not affect that phase.
- R7: Parameter `POL` selects the mode: value 0 (`CG_RISE`) gives rising mode and value 1 (`CG_FALL`) gives falling mode.
- R8: Every active output phase lasts exactly one input half-period: High phases in rising mode, Low phases in falling mode. Every resting phase lasts a whole number of half-periods. No runt phase occurs.
- R9: The number of output pulses equals the number of active clock edges at which the enable was 1.
- R10: `en_i` must be stable within a setup window before each clock edge. The stimulus that checks R2 to R9 never changes the enable inside that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running input clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the latched enable |
| en_i | input | 1 | Clock enable request |
| gclk_o | output | 1 | Gated clock |

## Verification
The critical overlap is an enable change that lands in the same clock period as a pulse already in flight. The latch is then holding one decision while a new one is requested. The bench provokes this by toggling the enable in the middle of every half-period, in both clock phases, and then at random offsets. Two instances, one per polarity, share the stimulus. A behavioural model that decides each pulse only at the active edge is compared against them at every time step. Phase lengths and pulse totals show whether a late enable change cut a pulse short or added a stray one.

// File: rtl/cg_pkg.sv
package cg_pkg;

    // Output polarity of the gate; value 0 rests Low, value 1 rests High
    typedef enum logic {
        CG_RISE = 1'b0,
        CG_FALL = 1'b1
    } cg_pol_e;

    // Latched enable state
    typedef struct packed {
        logic en;
    } cg_state_t;

endpackage

// File: rtl/cg_enable_latch.sv
module cg_enable_latch #(
    parameter bit OPEN_WHEN_HIGH = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic en_q_o
);
    import cg_pkg::*;

    cg_state_t st_d;
    cg_state_t st_q;
    logic      open_d;

    // Next value and transparency window
    always_comb begin
        st_d.en = en_i;
        open_d  = (clk_i == OPEN_WHEN_HIGH);
    end

    // Level-sensitive storage, cleared by reset
    always_latch begin
        if (!rst_ni) begin
            st_q.en <= 1'b0;
        end else if (open_d) begin
            st_q.en <= st_d.en;
        end
    end

    assign en_q_o = st_q.en;

endmodule

// File: rtl/cg_combine.sv
module cg_combine #(
    parameter cg_pkg::cg_pol_e POL = cg_pkg::CG_RISE
) (
    input  logic clk_i,
    input  logic en_q_i,
    output logic gclk_o
);
    generate
        if (POL == cg_pkg::CG_RISE) begin : g_and
            assign gclk_o = clk_i & en_q_i;
        end else begin : g_or
            assign gclk_o = clk_i | ~en_q_i;
        end
    endgenerate

endmodule

// File: rtl/cg_gate.sv
module cg_gate #(
    parameter cg_pkg::cg_pol_e POL = cg_pkg::CG_RISE
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic gclk_o
);
    import cg_pkg::*;

    localparam bit LATCH_OPEN_HIGH = (POL == CG_FALL);

    logic en_q;

    cg_enable_latch #(
        .OPEN_WHEN_HIGH(LATCH_OPEN_HIGH)
    ) u_latch (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .en_q_o(en_q)
    );

    cg_combine #(
        .POL(POL)
    ) u_combine (
        .clk_i (clk_i),
        .en_q_i(en_q),
        .gclk_o(gclk_o)
    );

    // R1: reset keeps the latch closed at 0
    a_r1_reset_clears: assert property (@(posedge clk_i) !rst_ni |-> !en_q);

    generate
        if (POL == CG_RISE) begin : g_chk_rise
            // R3: just before each rising edge the output rests Low
            a_r3_rest_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !gclk_o);
            // R4: the High phase ends with the output equal to the decision held
            a_r4_full_pulse: assert property (@(negedge clk_i) disable iff (!rst_ni)
                gclk_o == en_q);
        end else begin : g_chk_fall
            // R5: just before each falling edge the output rests High
            a_r5_rest_high: assert property (@(negedge clk_i) disable iff (!rst_ni)
                gclk_o);
            // R6: the Low phase ends with the output Low exactly when enabled
            a_r6_full_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
                gclk_o == !en_q);
        end
    endgenerate

endmodule

// File: tb/tb_cg_gate.sv
module tb_cg_gate;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int STEPS      = 4000;
    localparam int RST_STEPS  = 21;
    localparam int PH_C_START = 800;
    localparam int PH_C_END   = 1600;

    logic clk, rst_n, en;
    logic gclk_r, gclk_f;

    cg_gate #(.POL(cg_pkg::CG_RISE)) dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .gclk_o(gclk_r));

    cg_gate #(.POL(cg_pkg::CG_FALL)) dut_fall (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .gclk_o(gclk_f));

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            if (failures < 30)
                $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
        end
    endtask

    initial begin : main
        bit prev_clk, rpulse, fpulse, en_prev, last_r, last_f;
        bit exp_r, exp_f;
        int ph, start_r, start_f, rise_on, fall_on, rise_seen, fall_seen, viol;
        int unused;
        string rq;
        unused = $urandom(32'h00c0ffee);
        clk = 0; rst_n = 0; en = 0;
        rpulse = 0; fpulse = 0; last_r = 0; last_f = 1;
        start_r = 0; start_f = 0; rise_on = 0; fall_on = 0;
        rise_seen = 0; fall_seen = 0; viol = 0;
        for (int t = 0; t < STEPS; t++) begin
            prev_clk = clk;
            en_prev  = en;
            clk   = ((t / HALF) % 2) == 1;
            rst_n = (t >= RST_STEPS);
            ph    = t % HALF;
            if (ph >= 1 && ph <= 3) begin
                if (t < RST_STEPS) begin
                    if (ph == 2) en = ~en;                 // ignored under reset
                end else if (t < 400) begin
                    en = 1'b1;
                end else if (t < PH_C_START) begin
                    en = 1'b0;
                end else if (t < PH_C_END) begin
                    if (ph == 2) en = ~en;                 // toggles in every phase
                end else begin
                    if (($urandom % 3) == 0) en = 1'($urandom % 2);
                end
            end
            // R10: flag any enable change inside the setup window
            if (en != en_prev && (ph == 0 || ph == HALF - 1)) begin
                viol++;
                $display("NOTE setup window hit @%0t", $time);
            end
            // Reference: a pulse is decided only at the active edge
            if (!prev_clk && clk) begin
                rpulse = rst_n && en;
                if (rpulse) rise_on++;
            end
            if (prev_clk && !clk) begin
                fpulse = rst_n && en;
                if (fpulse) fall_on++;
            end
            if (!rst_n) begin
                rpulse = 0;
                fpulse = 0;
            end
            #0.5;
            exp_r = clk && rpulse;
            exp_f = clk || !fpulse;
            if (t == 0) begin
                chk(gclk_r === 1'b0 && gclk_f === 1'b1, "R7", "rest levels r/f",
                    {30'd0, gclk_r, gclk_f}, 1);
            end
            if (!rst_n) rq = "R1";
            else if (t >= PH_C_START && t < PH_C_END) rq = "R4";
            else rq = rpulse ? "R2" : "R3";
            chk(gclk_r === exp_r, rq, "rise output", int'(gclk_r), int'(exp_r));
            if (!rst_n) rq = "R1";
            else if (t >= PH_C_START && t < PH_C_END) rq = "R6";
            else rq = "R5";
            chk(gclk_f === exp_f, rq, "fall output", int'(gclk_f), int'(exp_f));
            // R8: phase lengths
            if (gclk_r !== last_r) begin
                if (last_r) chk((t - start_r) == HALF, "R8", "rise high len", t - start_r, HALF);
                else        chk(((t - start_r) % HALF) == 0, "R8", "rise low len mod", (t - start_r) % HALF, 0);
                if (!last_r) rise_seen++;
                last_r  = gclk_r;
                start_r = t;
            end
            if (gclk_f !== last_f) begin
                if (!last_f) chk((t - start_f) == HALF, "R8", "fall low len", t - start_f, HALF);
                else         chk(((t - start_f) % HALF) == 0, "R8", "fall high len mod", (t - start_f) % HALF, 0);
                if (last_f) fall_seen++;
                last_f  = gclk_f;
                start_f = t;
            end
            #0.5;
        end
        chk(rise_seen == rise_on, "R9", "rise pulse count", rise_seen, rise_on);
        chk(fall_seen == fall_on, "R9", "fall pulse count", fall_seen, fall_on);
        chk(rise_on > 0 && rise_on < STEPS / CLK_PERIOD, "R9", "mixed rise edges", rise_on, 1);
        chk(viol == 0, "R10", "setup window hits", viol, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        #(CLK_PERIOD * (STEPS + 200));
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not end actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule